// File: doc/BRIEF.md
# Hint-Driven Fetch Throttle Controller

This block sits beside the fetch stage of a wide-issue pipeline and decides, cycle by cycle, whether the fetch stage may run. Each decoded instruction group carries one hint bit prepared ahead of time by software tooling. The bit is set when the group is expected to offer little parallelism. The controller captures that bit in a register at decode. When the captured bit is set, it holds new fetch off for a programmable number of cycles, counted by a down-counter.

Both outputs come straight from flops. The fetch-enable qualifier can feed a glitch-free clock gate that tolerates a qualifier settling shortly after the rising edge. A busy status reports that a stall is in progress. A set hint that arrives while a stall is running restarts the stall from the full length; it never extends the stall by adding to it. A stall length of zero turns throttling off. A flush drops both the captured hint and any stall still running.

Top module: `hint_fetch_throttle`

## Requirements
- R1: A hint bit presented with `dec_valid` high is captured at the next rising edge. A hint bit presented with `dec_valid` low is ignored and never causes a stall.
- R2: Let the hint be captured at edge E0. `fetch_en` is then low after edges E1 through EL and high again after edge E(L+1), where L is the value of `stall_len` at edge E1.
- R3: Stall lengths 1, 2 and 3 each hold fetch off for exactly that many cycles. Length 1 is the default setting.
- R4: While no set hint is captured, `fetch_en` stays high, so fetch runs with no extra cycles.
- R5: A set hint captured during a stall reloads the counter to the full length. The stall then ends L cycles after the reload, and the two lengths are never added together.
- R6: A `stall_len` of 0 disables throttling: a captured hint leaves `fetch_en` high.
- R7: `flush` high at an edge clears the captured hint and any running stall, so `fetch_en` is high after that edge. When flush and a hint meet at the same edge, flush wins.
- R8: After reset, `fetch_en` is 1 and `throttle_busy` is 0. At every sample, `throttle_busy` is the inverse of `fetch_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | A decoded instruction group is present |
| dec_hint | input | 1 | Throttle hint bit of that group |
| stall_len | input | CNT_W | Stall length in cycles; 0 turns throttling off |
| flush | input | 1 | Cancel the captured hint and any running stall |
| fetch_en | output | 1 | Registered fetch-stage gate qualifier (1 = fetch runs) |
| throttle_busy | output | 1 | Registered status: a stall is in progress |

## Verification
The interesting collisions are a new hint landing while a stall is still counting down, and a flush landing on the same edge as a hint load or hint capture. The bench sweeps the gap between two hints across every stall length. It compares each cycle of `fetch_en` with the union of two windows computed arithmetically: a reload that added the lengths instead of restarting would lengthen that union. It also sweeps the flush position from the hint's own edge through the end of the stall. The expected result is a truncated window, and no window at all when flush meets the capture or the load.

// File: rtl/ft_pkg.sv
package ft_pkg;
    // Default width of the stall-length field (lengths 0..3).
    localparam int CNT_W_DEF = 2;

    // Control word steering the stall counter for one edge.
    typedef struct packed {
        logic clear;   // flush: drop any running stall
        logic load;    // start or restart a stall
    } cnt_ctrl_t;

    // Build the counter control from the latched hint, the length and flush.
    function automatic cnt_ctrl_t make_ctrl(input logic hint_q,
                                            input logic len_nonzero,
                                            input logic flush);
        cnt_ctrl_t c;
        c.clear = flush;
        c.load  = hint_q & len_nonzero & ~flush;
        return c;
    endfunction
endpackage

// File: rtl/ft_hint_latch.sv
module ft_hint_latch (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic dec_valid,
    input  logic dec_hint,
    output logic hint_q
);
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            hint_q <= 1'b0;
        end else begin
            hint_q <= dec_valid & dec_hint;
        end
    end
endmodule

// File: rtl/ft_stall_counter.sv
module ft_stall_counter
    import ft_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctrl_t        ctrl,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             fetch_en_q,
    output logic             busy_q
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        if (ctrl.clear) begin
            cnt_nxt = ZERO;
        end else if (ctrl.load) begin
            cnt_nxt = load_val;
        end else if (cnt_q != ZERO) begin
            cnt_nxt = cnt_q - ONE;
        end else begin
            cnt_nxt = ZERO;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= ZERO;
            fetch_en_q <= 1'b1;
            busy_q     <= 1'b0;
        end else begin
            cnt_q      <= cnt_nxt;
            fetch_en_q <= (cnt_nxt == ZERO);
            busy_q     <= (cnt_nxt != ZERO);
        end
    end
endmodule

// File: rtl/hint_fetch_throttle.sv
module hint_fetch_throttle
    import ft_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_valid,
    input  logic             dec_hint,
    input  logic [CNT_W-1:0] stall_len,
    input  logic             flush,
    output logic             fetch_en,
    output logic             throttle_busy
);
    logic             hint_q;
    logic [CNT_W-1:0] cnt_q;
    cnt_ctrl_t        ctrl;

    ft_hint_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .dec_valid (dec_valid),
        .dec_hint  (dec_hint),
        .hint_q    (hint_q)
    );

    assign ctrl = make_ctrl(hint_q, |stall_len, flush);

    ft_stall_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .load_val   (stall_len),
        .cnt_q      (cnt_q),
        .fetch_en_q (fetch_en),
        .busy_q     (throttle_busy)
    );
endmodule

// File: rtl/ft_checker.sv
module ft_checker #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             dec_valid,
    input logic             dec_hint,
    input logic [CNT_W-1:0] stall_len,
    input logic             flush,
    input logic             fetch_en,
    input logic             throttle_busy,
    input logic             hint_q,
    input logic [CNT_W-1:0] cnt_q
);
    AST_HINT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_hint && !flush) |=> hint_q);                      // R1

    AST_HINT_STALLS: assert property (@(posedge clk) disable iff (rst)
        (hint_q && stall_len != '0 && !flush) |=>
            (!fetch_en && cnt_q == $past(stall_len)));                      // R5

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (cnt_q > CNT_W'(1) && !hint_q && !flush) |=>
            (cnt_q == $past(cnt_q) - CNT_W'(1) && !fetch_en));              // R3

    AST_IDLE_RUNS: assert property (@(posedge clk) disable iff (rst)
        (!hint_q && cnt_q <= CNT_W'(1)) |=> fetch_en);                      // R4

    AST_ZERO_LEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (stall_len == '0 && cnt_q <= CNT_W'(1)) |=> fetch_en);              // R6

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush |=> (fetch_en && !hint_q && !throttle_busy));                 // R7

    AST_BUSY_INVERSE: assert property (@(posedge clk) disable iff (rst)
        (throttle_busy != fetch_en));                                       // R8
endmodule

bind hint_fetch_throttle ft_checker #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .dec_valid     (dec_valid),
    .dec_hint      (dec_hint),
    .stall_len     (stall_len),
    .flush         (flush),
    .fetch_en      (fetch_en),
    .throttle_busy (throttle_busy),
    .hint_q        (hint_q),
    .cnt_q         (cnt_q)
);

// File: tb/hint_fetch_throttle_tb_top.sv
module hint_fetch_throttle_tb_top;
    localparam int CNT_W = 2;

    logic             clk = 1'b0;
    logic             rst;
    logic             dec_valid;
    logic             dec_hint;
    logic [CNT_W-1:0] stall_len;
    logic             flush;
    logic             fetch_en;
    logic             throttle_busy;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    hint_fetch_throttle #(.CNT_W(CNT_W)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .dec_valid     (dec_valid),
        .dec_hint      (dec_hint),
        .stall_len     (stall_len),
        .flush         (flush),
        .fetch_en      (fetch_en),
        .throttle_busy (throttle_busy)
    );

    task automatic check(input string req, input logic exp_en, input int tag);
        n_checks++;
        if (fetch_en !== exp_en || throttle_busy !== ~exp_en) begin
            n_fail++;
            $display("FAIL %s case %0d: fetch_en=%b busy=%b expected fetch_en=%b busy=%b",
                     req, tag, fetch_en, throttle_busy, exp_en, ~exp_en);
        end
    endtask

    // Advance one edge and sample 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drain();
        dec_valid = 1'b0; dec_hint = 1'b0; flush = 1'b0;
        repeat (6) tick();
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; dec_valid = 1'b0; dec_hint = 1'b0; flush = 1'b0;
        stall_len = 2'd1;
        repeat (3) tick();
        // R8: reset state
        check("R8", 1'b1, 0);
        rst = 1'b0;
        tick();
        check("R8", 1'b1, 1);

        // R4: groups without a hint leave fetch running
        dec_valid = 1'b1; dec_hint = 1'b0;
        for (int j = 0; j < 6; j++) begin tick(); check("R4", 1'b1, j); end
        // R1: hint with dec_valid low is ignored
        dec_valid = 1'b0; dec_hint = 1'b1; stall_len = 2'd3;
        for (int j = 0; j < 6; j++) begin tick(); check("R1", 1'b1, j); end
        drain();

        // R2/R3/R6: single hint, every length; low after edges 1..L
        for (int len = 0; len < 4; len++) begin
            stall_len = CNT_W'(len);
            dec_valid = 1'b1; dec_hint = 1'b1;
            for (int j = 0; j < 7; j++) begin
                tick();
                dec_hint = 1'b0;
                check(len == 0 ? "R6" : (len == 1 ? "R2" : "R3"),
                      !(j >= 1 && j <= len), len * 10 + j);
            end
            drain();
        end

        // R5: second hint g cycles later; windows [1,L] and [g+1,g+L]
        for (int len = 1; len < 4; len++) begin
            for (int g = 1; g < 4; g++) begin
                stall_len = CNT_W'(len);
                dec_valid = 1'b1; dec_hint = 1'b1;
                for (int j = 0; j < 9; j++) begin
                    tick();
                    dec_hint = (j + 1 == g);
                    check("R5", !((j >= 1 && j <= len) || (j >= g + 1 && j <= g + len)),
                          len * 100 + g * 10 + j);
                end
                drain();
            end
        end

        // R7: flush at edge f; low only for 1 <= j <= L and j < f
        for (int len = 1; len < 4; len++) begin
            for (int f = 0; f < 4; f++) begin
                stall_len = CNT_W'(len);
                dec_valid = 1'b1; dec_hint = 1'b1; flush = (f == 0);
                for (int j = 0; j < 7; j++) begin
                    tick();
                    dec_hint = 1'b0;
                    flush = (j + 1 == f);
                    check("R7", !(j >= 1 && j <= len && j < f), len * 100 + f * 10 + j);
                end
                drain();
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule